// File: doc/BRIEF.md
# Serial Wiper Position Register

This block is the digital control logic of a dual digitally controlled potentiometer. A host drives a three-wire serial port: an enable line, a serial clock and a data line. While the enable line is high, each rising edge of the serial clock shifts one data bit into a frame register. When the enable line drops, the frame register is copied into holding registers. These hold two wiper positions and one select bit. The select bit chooses which wiper feeds the stacked output.

All three serial pins are sampled by a faster system clock through two-flop synchronizers. Edges are detected in that clock domain. A cascade output always presents the oldest bit of the frame register. This lets several devices be chained data-out to data-in. If the cascade output is looped back to the data input, the host can read the register without changing it.

Top module: `serial_wiper_ctl`

## Requirements
- R1: After reset, both wiper outputs, the select output, the stacked position and the cascade output are all zero.
- R2: Each frame is 17 bits. The first bit received becomes the select bit. The next 8 bits become wiper 1, most significant bit first. The last 8 bits become wiper 0, most significant bit first. When more than 17 bits are sent, only the final 17 count.
- R3: Wiper and select outputs change only after the enable line falls. They hold their values for the whole time the enable line is high.
- R4: Serial clock edges while the enable line is low do not change the frame register.
- R5: While the port is idle, the cascade output equals the select bit loaded at the last enable fall.
- R6: During a transaction, each serial clock rise shifts the frame toward the cascade output by one place. After n clock rises, the cascade output shows the n-th oldest bit of the prior contents (counting from zero).
- R7: A transaction of fewer than 17 bits is still loaded when the enable line falls. The new bits fill the top of the register, and the remaining old bits move down by the number of bits sent.
- R8: The stacked position output equals wiper 0 when the select bit is 0, and wiper 1 when it is 1.
- R9: A 17-bit transaction that feeds the cascade output back into the data input leaves the wipers and the select bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_en_i | input | 1 | Serial port enable, active high |
| ser_clk_i | input | 1 | Serial clock |
| ser_dat_i | input | 1 | Serial data in |
| casc_o | output | 1 | Cascade data out (oldest frame bit) |
| wiper0_o | output | 8 | Active wiper 0 position |
| wiper1_o | output | 8 | Active wiper 1 position |
| stack_sel_o | output | 1 | Stack select: 0 routes wiper 0, 1 routes wiper 1 |
| stack_pos_o | output | 8 | Position of the wiper routed to the stacked output |

## Verification
A fault in the frame register shows up on the cascade output within four system cycles of the serial clock edge that caused it, because every shift exposes a new oldest bit. A fault in the load path or the field mapping appears at the wiper outputs four system cycles after the enable line falls, as swapped or reversed bit positions. A stray load shows up as wiper movement while the enable line is still high. Loopback readback exposes any shift that loses or duplicates a bit, since the register would not return to its prior value.

// File: rtl/wiper_ctl_pkg.sv
package wiper_ctl_pkg;
  typedef enum int unsigned {
    LANE_EN  = 0,
    LANE_CLK = 1,
    LANE_DAT = 2
  } lane_e;
  localparam int unsigned N_LANES = 3;
  localparam int unsigned N_EDGE  = 2;  // lanes needing a delayed copy: enable, clock
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] pin_i,
  output logic [LANES-1:0] sync_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], pin_i[l]};
    end
    assign sync_o[l] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/level_delay.sv
module level_delay #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lvl_i,
  output logic [LANES-1:0] prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= lvl_i;
  end
endmodule

// File: rtl/frame_shreg.sv
module frame_shreg #(
  parameter int unsigned FRAME_W = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               casc_o
);
  // newest bit enters at the top, oldest leaves at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         frame_o <= '0;
    else if (shift_en_i) frame_o <= {bit_i, frame_o[FRAME_W-1:1]};
  end
  assign casc_o = frame_o[0];
endmodule

// File: rtl/wiper_hold.sv
module wiper_hold #(
  parameter int unsigned WIPER_W = 8,
  localparam int unsigned FRAME_W = 2 * WIPER_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic               stack_sel_o,
  output logic [WIPER_W-1:0] stack_pos_o
);
  localparam int unsigned W1_BASE = 1;
  localparam int unsigned W0_BASE = 1 + WIPER_W;

  logic [WIPER_W-1:0] w0_d, w1_d;

  // MSB of each field sits at its lowest frame index
  for (genvar k = 0; k < WIPER_W; k++) begin : g_map
    assign w1_d[WIPER_W-1-k] = frame_i[W1_BASE+k];
    assign w0_d[WIPER_W-1-k] = frame_i[W0_BASE+k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper0_o    <= '0;
      wiper1_o    <= '0;
      stack_sel_o <= 1'b0;
    end else if (load_i) begin
      wiper0_o    <= w0_d;
      wiper1_o    <= w1_d;
      stack_sel_o <= frame_i[0];
    end
  end

  assign stack_pos_o = stack_sel_o ? wiper1_o : wiper0_o;
endmodule

// File: rtl/serial_wiper_ctl.sv
module serial_wiper_ctl
  import wiper_ctl_pkg::*;
#(
  parameter int unsigned WIPER_W     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FRAME_W    = 2 * WIPER_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ser_en_i,
  input  logic               ser_clk_i,
  input  logic               ser_dat_i,
  output logic               casc_o,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic               stack_sel_o,
  output logic [WIPER_W-1:0] stack_pos_o
);
  logic [N_LANES-1:0] pins, pins_s;
  logic [N_EDGE-1:0]  prev;
  logic               port_on, shift_en, load_en;
  logic [FRAME_W-1:0] frame_q;

  assign pins[LANE_EN]  = ser_en_i;
  assign pins[LANE_CLK] = ser_clk_i;
  assign pins[LANE_DAT] = ser_dat_i;

  pin_sync #(.LANES(N_LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i(pins), .sync_o(pins_s)
  );

  level_delay #(.LANES(N_EDGE)) u_prev (
    .clk_i, .rst_ni, .lvl_i(pins_s[N_EDGE-1:0]), .prev_o(prev)
  );

  assign port_on  = pins_s[LANE_EN];
  assign shift_en = port_on & pins_s[LANE_CLK] & ~prev[LANE_CLK];
  assign load_en  = ~port_on & prev[LANE_EN];

  frame_shreg #(.FRAME_W(FRAME_W)) u_shreg (
    .clk_i, .rst_ni, .shift_en_i(shift_en), .bit_i(pins_s[LANE_DAT]),
    .frame_o(frame_q), .casc_o(casc_o)
  );

  wiper_hold #(.WIPER_W(WIPER_W)) u_hold (
    .clk_i, .rst_ni, .load_i(load_en), .frame_i(frame_q),
    .wiper0_o, .wiper1_o, .stack_sel_o, .stack_pos_o
  );
endmodule

// File: rtl/serial_wiper_ctl_chk.sv
module serial_wiper_ctl_chk #(
  parameter int unsigned WIPER_W = 8,
  localparam int unsigned FRAME_W = 2 * WIPER_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               port_on,
  input logic               shift_en,
  input logic               load_en,
  input logic [FRAME_W-1:0] frame_q,
  input logic               casc_o,
  input logic [WIPER_W-1:0] wiper0_o,
  input logic [WIPER_W-1:0] wiper1_o,
  input logic               stack_sel_o
);
  p_hold_while_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_on |=> $stable(wiper0_o) && $stable(wiper1_o) && $stable(stack_sel_o));

  p_no_shift_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_on |=> $stable(frame_q));

  p_casc_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_on && !load_en) |-> (casc_o == stack_sel_o));

  p_shift_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> frame_q[FRAME_W-2:0] == $past(frame_q[FRAME_W-1:1]));

  p_load_map_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> stack_sel_o == $past(frame_q[0])
             && wiper1_o[WIPER_W-1] == $past(frame_q[1])
             && wiper0_o[0] == $past(frame_q[FRAME_W-1]));
endmodule

bind serial_wiper_ctl serial_wiper_ctl_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_on(port_on), .shift_en(shift_en),
  .load_en(load_en), .frame_q(frame_q), .casc_o(casc_o),
  .wiper0_o(wiper0_o), .wiper1_o(wiper1_o), .stack_sel_o(stack_sel_o)
);

// File: tb/serial_wiper_ctl_tb.sv
module serial_wiper_ctl_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W  = 8;
  localparam int unsigned FW = 2 * W + 1;
  localparam int unsigned HALF = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic casc_o, stack_sel_o;
  logic [W-1:0] wiper0_o, wiper1_o, stack_pos_o;

  int n_chk = 0, n_bad = 0;
  logic [FW-1:0] mdl;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  serial_wiper_ctl #(.WIPER_W(W)) u_dut (
    .clk_i, .rst_ni, .ser_en_i(ser_en), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .casc_o, .wiper0_o, .wiper1_o, .stack_sel_o, .stack_pos_o
  );

  task automatic chk(input string rid, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rid, act, exp);
    end
  endtask

  // transmitted bit i of a frame: select, wiper1 MSB..LSB, wiper0 MSB..LSB
  function automatic logic [FW-1:0] make_frame(input logic s, input logic [W-1:0] a1,
                                                input logic [W-1:0] a0);
    logic [FW-1:0] f;
    f[0] = s;
    for (int k = 0; k < W; k++) begin
      f[1+k]   = a1[W-1-k];
      f[1+W+k] = a0[W-1-k];
    end
    return f;
  endfunction

  function automatic logic [W-1:0] field(input logic [FW-1:0] r, input int base);
    logic [W-1:0] v;
    for (int k = 0; k < W; k++) v[W-1-k] = r[base+k];
    return v;
  endfunction

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic xfer(input string rid, input int n, input logic [63:0] bits, input bit fb);
    logic [W-1:0] p0, p1, e0, e1;
    logic ps, b;
    p0 = wiper0_o; p1 = wiper1_o; ps = stack_sel_o;
    ser_en = 1'b1;
    wait_sys(HALF);
    for (int i = 0; i < n; i++) begin
      b = fb ? casc_o : bits[i];
      ser_dat = b;
      wait_sys(HALF);
      ser_clk = 1'b1;
      wait_sys(HALF);
      mdl = {b, mdl[FW-1:1]};
      chk("R6 casc in transaction", casc_o, mdl[0]);
      ser_clk = 1'b0;
    end
    wait_sys(HALF);
    chk("R3 hold w0", wiper0_o, p0);
    chk("R3 hold w1", wiper1_o, p1);
    chk("R3 hold sel", stack_sel_o, ps);
    ser_en = 1'b0;
    wait_sys(HALF);
    e0 = field(mdl, 1 + W);
    e1 = field(mdl, 1);
    chk({rid, " w0"}, wiper0_o, e0);
    chk({rid, " w1"}, wiper1_o, e1);
    chk({rid, " sel"}, stack_sel_o, mdl[0]);
    chk("R8 stack pos", stack_pos_o, mdl[0] ? e1 : e0);
    chk("R5 casc idle", casc_o, mdl[0]);
  endtask

  task automatic full_frame(input logic s, input logic [W-1:0] a1, input logic [W-1:0] a0);
    xfer("R2", FW, {{(64-FW){1'b0}}, make_frame(s, a1, a0)}, 1'b0);
    chk("R2 direct w1", wiper1_o, a1);
    chk("R2 direct w0", wiper0_o, a0);
    chk("R2 direct sel", stack_sel_o, s);
  endtask

  initial begin
    bit done;
    done = 1'b0;
    fork
      begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
          $finish;
        end
      end
    join_none

    void'($urandom(32'h5eed_0042));
    mdl = '0;
    wait_sys(3);
    rst_ni = 1'b1;
    wait_sys(2);
    chk("R1 w0", wiper0_o, 0);
    chk("R1 w1", wiper1_o, 0);
    chk("R1 sel", stack_sel_o, 0);
    chk("R1 pos", stack_pos_o, 0);
    chk("R1 casc", casc_o, 0);

    full_frame(1'b1, 8'h80, 8'h01);
    full_frame(1'b0, 8'hFF, 8'h00);
    full_frame(1'b1, 8'hA5, 8'h5A);
    full_frame(1'b0, 8'h01, 8'hC3);
    for (int t = 0; t < 12; t++)
      full_frame(1'($urandom), 8'($urandom), 8'($urandom));

    // R4: serial clocks with the port idle
    begin
      logic [W-1:0] q0, q1;
      logic qs, qc;
      q0 = wiper0_o; q1 = wiper1_o; qs = stack_sel_o; qc = casc_o;
      for (int i = 0; i < 5; i++) begin
        ser_dat = 1'($urandom);
        wait_sys(HALF); ser_clk = 1'b1; wait_sys(HALF); ser_clk = 1'b0;
      end
      wait_sys(HALF);
      chk("R4 casc", casc_o, qc);
      chk("R4 w0", wiper0_o, q0);
      // R9: loopback readback; also exposes any idle shift
      xfer("R9", FW, 64'd0, 1'b1);
      chk("R9 w0 kept", wiper0_o, q0);
      chk("R9 w1 kept", wiper1_o, q1);
      chk("R9 sel kept", stack_sel_o, qs);
    end

    // R7: short and odd-length transactions
    xfer("R7", 5, 64'h15, 1'b0);
    xfer("R7", 11, {32'd0, $urandom}, 1'b0);
    full_frame(1'b1, 8'h3C, 8'hE7);

    // R2: a double frame, last 17 bits win; R6 sees the first frame emerge
    begin
      logic [FW-1:0] fa, fb2;
      fa  = make_frame(1'b0, 8'h12, 8'h34);
      fb2 = make_frame(1'b1, 8'hDE, 8'hAD);
      xfer("R2", 2 * FW, {{(64-2*FW){1'b0}}, fb2, fa}, 1'b0);
      chk("R2 double w1", wiper1_o, 8'hDE);
      chk("R2 double w0", wiper0_o, 8'hAD);
    end

    for (int t = 0; t < 6; t++)
      xfer("R7", 1 + int'($urandom % 16), {$urandom, $urandom}, 1'b0);
    xfer("R9", FW, 64'd0, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule